// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block sits between a core's read port and a memory that can deliver four-longword bursts. It owns a small direct-mapped cache of four-longword lines. A cacheable read that hits is answered from the cache and causes no memory traffic. A cacheable read that misses starts a burst that begins at the longword the core asked for. That longword goes back to the core as soon as it arrives. The other three follow in wrap-around order and are written into the line.

The line becomes usable only once all four longwords are stored. Then a separate commit strobe writes its tag and sets its valid bit. A read marked cache-inhibited fetches one longword from memory and leaves the cache alone. The core is held off while a request is in progress, so a request made during a fill waits until the line is committed.

All addresses are longword addresses, so bit 0 of an address selects a 32-bit word. The line write port is visible at the block's edge, so a neighbour can mirror the line contents or trace the fill.

Top module: `cwf_line_fill`

## Requirements
- R1: The cache is direct-mapped with 2**IDX_W lines of four longwords. In a longword address, bits [1:0] select the word, bits [IDX_W+1:2] select the line and the remaining upper bits form the tag.
- R2: A cacheable miss issues one memory request with mem_rd_burst=1. Its mem_rd_addr equals the requested longword address.
- R3: On a cacheable miss, core_rvalid pulses with the first returned beat's data. That happens in the same cycle as the line write of the requested word, and before the commit strobe.
- R4: Each memory beat of a fill is written through the line port (lw_en, lw_word). The word indices run crit, crit+1, crit+2, crit+3 modulo 4, where crit is bits [1:0] of the request.
- R5: lw_commit pulses once per fill with lw_tag and lw_index of the line. It comes exactly one cycle after the fourth lw_en. A later read of any word of that line is a hit returning the filled data.
- R6: A cacheable hit returns the cached longword with core_rvalid two cycles after the accepting clock edge, and issues no memory request.
- R7: A cache-inhibited read (core_nocache=1) issues one request with mem_rd_burst=0 and returns the memory data. It makes no line write and no commit, and leaves any cached copy of the line unchanged.
- R8: core_ready is low from acceptance until the response (hit or inhibited) or until the commit cycle (fill). A request presented meanwhile waits and is accepted only when core_ready returns.
- R9: Synchronous active-low reset invalidates every line and brings core_ready=1, mem_rd_req=0, core_rvalid=0, lw_en=0 and lw_commit=0.
- R10: mem_rd_req, once raised, stays high with a stable mem_rd_addr until the cycle where mem_rd_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core read request, taken when core_ready is high |
| core_addr | input | WADDR_W | Longword address of the read |
| core_nocache | input | 1 | Read is cache-inhibited |
| core_ready | output | 1 | Block can take a request this cycle |
| core_rvalid | output | 1 | One-cycle pulse with read data |
| core_rdata | output | DATA_W | Read data |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | WADDR_W | First longword address of the access |
| mem_rd_burst | output | 1 | 1: four-beat wrapping burst, 0: single beat |
| mem_rd_gnt | input | 1 | Memory accepts the request |
| mem_rd_vld | input | 1 | Memory beat valid |
| mem_rd_data | input | DATA_W | Memory beat data |
| lw_en | output | 1 | Line port word write strobe |
| lw_index | output | IDX_W | Line index being written or committed |
| lw_word | output | 2 | Word within the line |
| lw_data | output | DATA_W | Word data |
| lw_commit | output | 1 | Tag write and valid set for lw_index |
| lw_tag | output | WADDR_W-IDX_W-2 | Tag written on commit |

## Verification
The bench fills lines whose critical word is 0, 1, 2 and 3, and checks the exact order of word writes. A controller that always started at word 0, or that wrapped wrongly, would show a different order. It would also return wrong data on the later hits. A salt changes the memory contents between requests, so the bench can tell a true hit from a silent refetch. The same salt shows that an inhibited read of a cached line reaches memory and leaves the old copy intact. A design that allocated on an inhibited read would turn the next cacheable read into a hit with stale data.

Two further cases target timing. A request raised during a slow fill must wait until the commit cycle and then hit. A controller that released the core early would refetch, or would answer from a half-written line. The bench also stretches grant delays to check that the request is held steady, and resets mid-run to check that every line is forgotten.

// File: rtl/cwf_pkg.sv
// Package: shared types and helpers of the critical-word-first line fill block.
// Assumes four longwords per line, so the word offset is always two bits wide.
package cwf_pkg;
    localparam int WORDS_PER_LINE = 4;
    localparam int WOFS_W         = 2;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a core request
        ST_LOOK,    // tag compare of the captured request
        ST_REQ,     // memory request raised, waiting for grant
        ST_FILL,    // receiving four beats of a line fill
        ST_SINGLE,  // receiving the single beat of an inhibited read
        ST_COMMIT   // last word stored, tag and valid written next
    } fill_state_e;

    // Next word index of a wrapping fill.
    function automatic logic [WOFS_W-1:0] wrap_next(input logic [WOFS_W-1:0] w);
        return w + 2'd1;
    endfunction
endpackage

// File: rtl/cwf_tag_store.sv
// Module: valid and tag array of the direct-mapped cache.
// Assumes invalidate and commit never address the same line in one cycle.
// Reset clears every valid bit; tags are left as they are.
module cwf_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval_en,
    input  logic [IDX_W-1:0] inval_idx,
    input  logic             commit_en,
    input  logic [IDX_W-1:0] commit_idx,
    input  logic [TAG_W-1:0] commit_tag,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid,
    output logic [TAG_W-1:0] look_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line valid bit: cleared by reset or invalidate, set by commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (inval_en && inval_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b0;
            end else if (commit_en && commit_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
            end
        end

        // Per-line tag register, loaded on commit.
        always_ff @(posedge clk) begin
            if (commit_en && commit_idx == IDX_W'(g)) begin
                tag_q[g] <= commit_tag;
            end
        end
    end

    // Combinational lookup of the addressed line.
    always_comb begin
        look_valid = valid_q[look_idx];
        look_tag   = tag_q[look_idx];
    end

    // R9: a line is never valid in the cycle right after reset.
    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(!rst_n) |-> valid_q == '0);
endmodule

// File: rtl/cwf_data_store.sv
// Module: longword data array, one write port and one combinational read port.
// Assumes contents need no reset, since valid bits gate every use.
module cwf_data_store #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        rd_word,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = (1 << IDX_W) * cwf_pkg::WORDS_PER_LINE;

    logic [DATA_W-1:0] mem_q [ENTRIES];

    // Store one longword per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_word}] <= wr_data;
        end
    end

    // Read the addressed longword without a clock.
    assign rd_data = mem_q[{rd_idx, rd_word}];
endmodule

// File: rtl/cwf_fill_fsm.sv
// Module: request sequencer. It takes a core read, compares tags, answers hits,
// runs wrapping four-beat fills with the critical word forwarded, runs single
// inhibited reads, and drives the registered line write port.
// Assumes the memory returns burst beats in wrap order from mem_rd_addr.
module cwf_fill_fsm #(
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = WADDR_W - IDX_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_req,
    input  logic [WADDR_W-1:0] core_addr,
    input  logic               core_nocache,
    output logic               core_ready,
    output logic               core_rvalid,
    output logic [DATA_W-1:0]  core_rdata,
    output logic               mem_rd_req,
    output logic [WADDR_W-1:0] mem_rd_addr,
    output logic               mem_rd_burst,
    input  logic               mem_rd_gnt,
    input  logic               mem_rd_vld,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic [IDX_W-1:0]   look_idx,
    output logic [1:0]         look_word,
    input  logic               look_valid,
    input  logic [TAG_W-1:0]   look_tag,
    input  logic [DATA_W-1:0]  cache_rdata,
    output logic               inval_en,
    output logic               lw_en,
    output logic [IDX_W-1:0]   lw_index,
    output logic [1:0]         lw_word,
    output logic [DATA_W-1:0]  lw_data,
    output logic               lw_commit,
    output logic [TAG_W-1:0]   lw_tag
);
    import cwf_pkg::*;

    fill_state_e        state_q;
    logic [WADDR_W-1:0] req_addr_q;
    logic               req_nc_q;
    logic [1:0]         beat_q;
    logic [1:0]         fill_word_q;

    logic [TAG_W-1:0]   req_tag;
    logic [IDX_W-1:0]   req_idx;
    logic [1:0]         req_word;
    logic               hit;

    // Split the captured longword address into tag, line and word.
    always_comb begin
        req_tag  = req_addr_q[WADDR_W-1 -: TAG_W];
        req_idx  = req_addr_q[IDX_W+1:2];
        req_word = req_addr_q[1:0];
        hit      = look_valid && (look_tag == req_tag);
    end

    // Drive the lookup, core handshake and memory request from the state.
    always_comb begin
        look_idx     = req_idx;
        look_word    = req_word;
        core_ready   = (state_q == ST_IDLE);
        mem_rd_req   = (state_q == ST_REQ);
        mem_rd_addr  = req_addr_q;
        mem_rd_burst = !req_nc_q;
        inval_en     = (state_q == ST_REQ) && mem_rd_gnt && !req_nc_q;
    end

    // Main sequencer with registered core response and line port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_nc_q    <= 1'b0;
            beat_q      <= '0;
            fill_word_q <= '0;
            core_rvalid <= 1'b0;
            core_rdata  <= '0;
            lw_en       <= 1'b0;
            lw_index    <= '0;
            lw_word     <= '0;
            lw_data     <= '0;
            lw_commit   <= 1'b0;
            lw_tag      <= '0;
        end else begin
            core_rvalid <= 1'b0;
            lw_en       <= 1'b0;
            lw_commit   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (core_req) begin
                        req_addr_q <= core_addr;
                        req_nc_q   <= core_nocache;
                        state_q    <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (!req_nc_q && hit) begin
                        core_rvalid <= 1'b1;
                        core_rdata  <= cache_rdata;
                        state_q     <= ST_IDLE;
                    end else begin
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_rd_gnt) begin
                        beat_q      <= '0;
                        fill_word_q <= req_word;
                        state_q     <= req_nc_q ? ST_SINGLE : ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_vld) begin
                        lw_en       <= 1'b1;
                        lw_index    <= req_idx;
                        lw_word     <= fill_word_q;
                        lw_data     <= mem_rd_data;
                        fill_word_q <= wrap_next(fill_word_q);
                        beat_q      <= beat_q + 2'd1;
                        if (beat_q == 2'd0) begin
                            core_rvalid <= 1'b1;
                            core_rdata  <= mem_rd_data;
                        end
                        if (beat_q == 2'd3) begin
                            state_q <= ST_COMMIT;
                        end
                    end
                end
                ST_SINGLE: begin
                    if (mem_rd_vld) begin
                        core_rvalid <= 1'b1;
                        core_rdata  <= mem_rd_data;
                        state_q     <= ST_IDLE;
                    end
                end
                ST_COMMIT: begin
                    lw_commit <= 1'b1;
                    lw_tag    <= req_tag;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Assertion helpers: line writes seen since the last commit, and the last word index.
    logic [2:0] wr_seen_q;
    logic [1:0] last_word_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_q   <= '0;
            last_word_q <= '0;
        end else begin
            wr_seen_q <= lw_commit ? 3'd0 : wr_seen_q + {2'b00, lw_en};
            if (lw_en) last_word_q <= lw_word;
        end
    end

    // R10: the request is held with a steady address until granted.
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_gnt |=> mem_rd_req && $stable(mem_rd_addr));

    // R5: a commit follows exactly four word writes.
    assert_commit_after_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lw_commit |-> wr_seen_q == 3'd4);

    // R5: the commit comes in the cycle right after the fourth write.
    assert_commit_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en && wr_seen_q == 3'd3 |=> lw_commit);

    // R4: every write after the first advances the word index by one, modulo 4.
    assert_wrap_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en && wr_seen_q != 3'd0 |-> lw_word == last_word_q + 2'd1);

    // R3: the forwarded word is the first write of its fill.
    assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_rvalid && lw_en |-> wr_seen_q == 3'd0 && lw_word == req_word);

    // R8: the core is held off while line words are being written.
    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en |-> !core_ready);

    // R7: a single-beat request never leads to line writes.
    assert_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_burst |=> !lw_en && !lw_commit);
endmodule

// File: rtl/cwf_line_fill.sv
// Module: top of the critical-word-first line fill controller.
// It joins the sequencer, the tag store and the data store. The line write port
// drives the internal data store and tag store and is also brought out.
// Assumes longword addresses and a memory that wraps bursts inside the line.
module cwf_line_fill #(
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 4,
    localparam int TAG_W  = WADDR_W - IDX_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_req,
    input  logic [WADDR_W-1:0] core_addr,
    input  logic               core_nocache,
    output logic               core_ready,
    output logic               core_rvalid,
    output logic [DATA_W-1:0]  core_rdata,
    output logic               mem_rd_req,
    output logic [WADDR_W-1:0] mem_rd_addr,
    output logic               mem_rd_burst,
    input  logic               mem_rd_gnt,
    input  logic               mem_rd_vld,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               lw_en,
    output logic [IDX_W-1:0]   lw_index,
    output logic [1:0]         lw_word,
    output logic [DATA_W-1:0]  lw_data,
    output logic               lw_commit,
    output logic [TAG_W-1:0]   lw_tag
);
    logic [IDX_W-1:0]  look_idx;
    logic [1:0]        look_word;
    logic              look_valid;
    logic [TAG_W-1:0]  look_tag;
    logic [DATA_W-1:0] cache_rdata;
    logic              inval_en;

    cwf_fill_fsm #(
        .WADDR_W(WADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_addr(core_addr), .core_nocache(core_nocache),
        .core_ready(core_ready), .core_rvalid(core_rvalid), .core_rdata(core_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_burst(mem_rd_burst),
        .mem_rd_gnt(mem_rd_gnt), .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
        .look_idx(look_idx), .look_word(look_word), .look_valid(look_valid),
        .look_tag(look_tag), .cache_rdata(cache_rdata), .inval_en(inval_en),
        .lw_en(lw_en), .lw_index(lw_index), .lw_word(lw_word), .lw_data(lw_data),
        .lw_commit(lw_commit), .lw_tag(lw_tag)
    );

    cwf_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
        .clk(clk), .rst_n(rst_n),
        .inval_en(inval_en), .inval_idx(look_idx),
        .commit_en(lw_commit), .commit_idx(lw_index), .commit_tag(lw_tag),
        .look_idx(look_idx), .look_valid(look_valid), .look_tag(look_tag)
    );

    cwf_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_data (
        .clk(clk),
        .wr_en(lw_en), .wr_idx(lw_index), .wr_word(lw_word), .wr_data(lw_data),
        .rd_idx(look_idx), .rd_word(look_word), .rd_data(cache_rdata)
    );

    // R6: a response that follows no memory beat is a hit, and no request is then pending.
    assert_hit_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_rvalid && !$past(mem_rd_vld) |-> !mem_rd_req);
endmodule

// File: tb/test_cwf_line_fill.sv
// Bench: a vector table walked by one loop, then directed stall and reset tests.
module test_cwf_line_fill;
    localparam int WADDR_W = 30;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 4;
    localparam int TAG_W   = WADDR_W - IDX_W - 2;
    localparam int NVEC    = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 1'b0;
    logic [WADDR_W-1:0] core_addr = '0;
    logic core_nocache = 1'b0;
    logic core_ready, core_rvalid;
    logic [DATA_W-1:0] core_rdata;
    logic mem_rd_req, mem_rd_burst;
    logic [WADDR_W-1:0] mem_rd_addr;
    logic mem_rd_gnt = 1'b0;
    logic mem_rd_vld = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic lw_en, lw_commit;
    logic [IDX_W-1:0] lw_index;
    logic [1:0] lw_word;
    logic [DATA_W-1:0] lw_data;
    logic [TAG_W-1:0] lw_tag;

    always #2 clk = ~clk;

    cwf_line_fill #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_cwf_line_fill (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_addr(core_addr),
        .core_nocache(core_nocache), .core_ready(core_ready), .core_rvalid(core_rvalid),
        .core_rdata(core_rdata), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_burst(mem_rd_burst), .mem_rd_gnt(mem_rd_gnt), .mem_rd_vld(mem_rd_vld),
        .mem_rd_data(mem_rd_data), .lw_en(lw_en), .lw_index(lw_index), .lw_word(lw_word),
        .lw_data(lw_data), .lw_commit(lw_commit), .lw_tag(lw_tag)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Entry: [38:9] longword address, [8] inhibited, [7] hit expected,
    // [6:3] salt of the fill that supplies the data, [2] beat gap, [1:0] grant wait.
    localparam logic [38:0] VEC [NVEC] = '{
        {30'h0402, 1'b0, 1'b0, 4'd0,  1'b0, 2'd0},
        {30'h0400, 1'b0, 1'b1, 4'd0,  1'b0, 2'd0},
        {30'h0403, 1'b0, 1'b1, 4'd0,  1'b0, 2'd0},
        {30'h0811, 1'b1, 1'b0, 4'd3,  1'b0, 2'd2},
        {30'h0811, 1'b0, 1'b0, 4'd4,  1'b1, 2'd1},
        {30'h0812, 1'b0, 1'b1, 4'd4,  1'b0, 2'd0},
        {30'h0C00, 1'b0, 1'b0, 4'd6,  1'b0, 2'd3},
        {30'h0401, 1'b0, 1'b0, 4'd7,  1'b1, 2'd0},
        {30'h0401, 1'b1, 1'b0, 4'd8,  1'b0, 2'd0},
        {30'h0400, 1'b0, 1'b1, 4'd7,  1'b0, 2'd0},
        {30'h043F, 1'b0, 1'b0, 4'd10, 1'b0, 2'd1},
        {30'h043C, 1'b0, 1'b1, 4'd10, 1'b0, 2'd0},
        {30'h0813, 1'b0, 1'b1, 4'd4,  1'b0, 2'd0}
    };

    // Memory contents: depend on the address and on a salt the bench changes.
    logic [3:0] salt = '0;
    bit beat_gap = 1'b0;
    int gnt_wait = 0;
    int nreq = 0;
    logic [WADDR_W-1:0] last_addr = '0;
    logic last_burst = 1'b0;

    function automatic logic [31:0] memval(input logic [WADDR_W-1:0] a, input logic [3:0] s);
        return {s, a[27:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: grant after a wait, then beats in wrap order from the given address.
    initial begin
        logic [WADDR_W-1:0] a;
        logic b;
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                a = mem_rd_addr;
                b = mem_rd_burst;
                for (int w = 0; w < gnt_wait; w++) begin
                    @(negedge clk);
                    chk(mem_rd_req && mem_rd_addr == a, "R10 request held", {2'b0, mem_rd_addr}, {2'b0, a});
                end
                mem_rd_gnt = 1'b1;
                @(negedge clk);
                mem_rd_gnt = 1'b0;
                nreq++;
                last_addr = a;
                last_burst = b;
                for (int k = 0; k < (b ? 4 : 1); k++) begin
                    mem_rd_vld = 1'b1;
                    mem_rd_data = memval({a[WADDR_W-1:2], a[1:0] + 2'(k)}, salt);
                    @(negedge clk);
                    if (beat_gap) begin
                        mem_rd_vld = 1'b0;
                        @(negedge clk);
                    end
                end
                mem_rd_vld = 1'b0;
            end
        end
    end

    // Line port monitor: logs word indices and counts commits.
    logic [1:0] wlog [8];
    int wcnt = 0;
    int ccnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (lw_en) begin
                if (wcnt < 8) wlog[wcnt] = lw_word;
                wcnt++;
            end
            if (lw_commit) ccnt++;
        end
    end

    // One read: issue, time the response, wait for quiet, then check the outcome.
    task automatic do_read(input logic [38:0] v, input logic [3:0] s, input string nm);
        logic [WADDR_W-1:0] a;
        logic nc, hit;
        logic [3:0] src;
        int lat, n0;
        logic [31:0] got;
        logic fw_en, fw_commit;
        logic [1:0] fw_word;
        a = v[38:9]; nc = v[8]; hit = v[7]; src = v[6:3];
        @(negedge clk);
        beat_gap = v[2];
        gnt_wait = int'(v[1:0]);
        salt = s;
        wcnt = 0;
        ccnt = 0;
        n0 = nreq;
        core_req = 1'b1;
        core_addr = a;
        core_nocache = nc;
        while (!core_ready) @(negedge clk);
        @(negedge clk);
        core_req = 1'b0;
        lat = 1;
        while (!core_rvalid) begin
            @(negedge clk);
            lat++;
        end
        got = core_rdata;
        fw_en = lw_en;
        fw_word = lw_word;
        fw_commit = lw_commit;
        while (!core_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        if (hit) begin
            chk(got == memval(a, src), {nm, " R6 hit data"}, got, memval(a, src));
            chk(nreq == n0, {nm, " R6 hit without memory"}, nreq - n0, 0);
            chk(lat == 2, {nm, " R6 hit latency"}, lat, 2);
            chk(wcnt == 0 && ccnt == 0, {nm, " R6 hit writes nothing"}, wcnt, 0);
        end else if (nc) begin
            chk(got == memval(a, src), {nm, " R7 inhibited data"}, got, memval(a, src));
            chk(nreq == n0 + 1 && last_burst == 1'b0, {nm, " R7 single request"}, {nreq - n0, 31'(last_burst)}, 2);
            chk(wcnt == 0 && ccnt == 0, {nm, " R7 no allocation"}, wcnt + ccnt, 0);
        end else begin
            chk(got == memval(a, src), {nm, " R3 critical data"}, got, memval(a, src));
            chk(nreq == n0 + 1 && last_burst == 1'b1, {nm, " R2 burst request"}, {nreq - n0, 31'(last_burst)}, 3);
            chk(last_addr == a, {nm, " R2 request address"}, {2'b0, last_addr}, {2'b0, a});
            chk(fw_en && fw_word == a[1:0] && !fw_commit, {nm, " R3 forwarded with first write"},
                {fw_en, fw_commit, 28'b0, fw_word}, {1'b1, 1'b0, 28'b0, a[1:0]});
            chk(wcnt == 4, {nm, " R4 four writes"}, wcnt, 4);
            for (int i = 0; i < 4; i++) begin
                chk(wlog[i] == a[1:0] + 2'(i), {nm, " R4 wrap order"}, {30'b0, wlog[i]}, {30'b0, a[1:0] + 2'(i)});
            end
            chk(ccnt == 1, {nm, " R5 one commit"}, ccnt, 1);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state.
        chk(core_ready && !mem_rd_req && !core_rvalid && !lw_en && !lw_commit, "R9 reset outputs",
            {core_ready, mem_rd_req, core_rvalid, lw_en, lw_commit}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 is exercised by the index and tag choices of the table: lines 0, 4 and 15 and a tag conflict on line 0.
        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i], 4'(i), $sformatf("vec%0d", i));
        end

        // R8: a request during a slow fill waits until the commit cycle, then hits.
        begin
            int n0;
            logic [31:0] got;
            bit ready_in_fill;
            @(negedge clk);
            beat_gap = 1'b1;
            gnt_wait = 0;
            salt = 4'd14;
            core_req = 1'b1;
            core_addr = 30'h1000;
            core_nocache = 1'b0;
            while (!core_ready) @(negedge clk);
            @(negedge clk);
            core_req = 1'b0;
            while (!core_rvalid) @(negedge clk);
            n0 = nreq;
            core_req = 1'b1;
            core_addr = 30'h1001;
            ready_in_fill = 1'b0;
            @(negedge clk);
            while (!core_ready) begin
                if (lw_en) ready_in_fill = ready_in_fill | core_ready;
                @(negedge clk);
            end
            chk(!ready_in_fill, "R8 held off during fill", 32'(ready_in_fill), 0);
            chk(lw_commit, "R8 released in commit cycle", 32'(lw_commit), 1);
            @(negedge clk);
            core_req = 1'b0;
            while (!core_rvalid) @(negedge clk);
            got = core_rdata;
            chk(got == memval(30'h1001, 4'd14), "R5 stalled read hits filled line", got, memval(30'h1001, 4'd14));
            chk(nreq == n0, "R8 stalled read made no request", nreq - n0, 0);
            repeat (3) @(negedge clk);
        end

        // R9: reset mid-run forgets every line.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(core_ready && !mem_rd_req && !core_rvalid, "R9 reset outputs mid-run",
            {core_ready, mem_rd_req, core_rvalid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        do_read({30'h0400, 1'b0, 1'b0, 4'd15, 1'b0, 2'd0}, 4'd15, "R9 after reset");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule